// File: doc/BRIEF.md
# MII Transmit Nibble Framer

This block sits between a byte-wide MAC transmit path and the 4-bit media-independent transmit interface of an external PHY. It runs entirely in the PHY-supplied transmit clock domain (25 MHz at 100 Mbps, 2.5 MHz at 10 Mbps). On each frame it drives the preamble and start delimiter, then the payload one nibble per clock, then zero padding up to the minimum size, and then a 32-bit frame check sequence. All outputs come straight from flops and change only on rising clock edges.

The MAC supplies bytes on a valid/ready stream. Start and end markers travel with the bytes. A MAC that stops presenting data in the middle of a frame ends the payload early, and the block pads and closes the frame itself. The collision input from the PHY is asynchronous. It passes through a synchronizer and then sets a sticky flag that stays set until the next frame begins.

Top module: `mii_tx_framer`

## Requirements
- R1: After reset and whenever no frame is being sent, `tx_en` is 0, `txd` is 0 and `in_ready` is 1.
- R2: In idle, a byte with `in_valid` and `in_sop` both high starts a frame. On the next rising edge `tx_en` goes to 1 and `txd` carries the first preamble nibble 0x5. A byte offered in idle without `in_sop` is consumed and dropped, and no frame starts.
- R3: Each frame opens with 15 nibbles of 0x5 followed by one nibble of 0xD.
- R4: Each payload byte goes out as two nibbles: bits 3:0 first, then bits 7:4. `txd[0]` carries the lowest bit of each nibble.
- R5: A payload shorter than 60 bytes is followed by zero bytes until 60 bytes have been sent. Longer payloads get no padding.
- R6: After the payload and any padding come 8 nibbles of CRC-32. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones, covers the payload and pad bytes, and is sent complemented, lowest nibble first.
- R7: `tx_en` stays high through the last CRC nibble and falls on the next edge. Consecutive frames are separated by at least one clock with `tx_en` low. When the next start byte is already waiting, the gap is exactly one clock.
- R8: If `in_valid` is low when the next payload byte is due, and that byte has not carried `in_eop`, the payload ends there. The frame is then padded as in R5 and closed as in R6.
- R9: A payload stops after 1514 bytes even without `in_eop`. From that point `in_ready` stays 0 until the frame has ended.
- R10: `col_async` passes through a two-flop synchronizer. A synchronized collision while `tx_en` is high sets `col_flag`. The flag holds until the next frame starts and clears on the same edge that raises `tx_en`. A collision seen while idle leaves the flag unchanged.
- R11: `in_ready` is 0 during the preamble and delimiter nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Payload byte from the MAC |
| in_valid | input | 1 | `in_data` is valid |
| in_sop | input | 1 | Byte is the first of a frame |
| in_eop | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Block accepts the byte on this edge |
| col_async | input | 1 | Collision indication from the PHY, asynchronous |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable |
| col_flag | output | 1 | Sticky collision flag for the current or last frame |

## Verification
A wrong state register shows up at `txd` on the very next nibble. A miscounted preamble shifts the 0xD delimiter off position 16, and a wrong byte counter changes the frame length by at least two nibbles. A corrupted CRC register changes all eight check nibbles, but only at the end of the frame, so every frame is compared nibble for nibble against a CRC computed independently. Synchronizer or flag faults appear at `col_flag` within three clocks of a collision, or at the first nibble of the following frame.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_SFD, ST_LO, ST_HI, ST_PAD_LO, ST_PAD_HI, ST_FCS
    } tx_state_e;
endpackage

// File: rtl/mii_col_sync.sv
module mii_col_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[STAGES-2:0], async_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/mii_tx_crc.sv
module mii_tx_crc #(
    parameter logic [31:0] POLY = 32'hEDB88320
) (
    input  logic [31:0] crc_i,
    input  logic [7:0]  data_i,
    output logic [31:0] crc_o
);
    always_comb begin
        crc_o = crc_i;
        for (int b = 0; b < 8; b++) begin
            crc_o = (crc_o >> 1) ^ (((crc_o[0] ^ data_i[b]) != 1'b0) ? POLY : 32'h0);
        end
    end
endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
    import mii_tx_pkg::*;
#(
    parameter int PRE_NIBBLES = 15,
    parameter int MIN_DATA    = 60,
    parameter int MAX_DATA    = 1514,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic       in_eop,
    output logic       in_ready,
    input  logic       col_async,
    output logic [3:0] txd,
    output logic       tx_en,
    output logic       col_flag
);
    localparam int CNT_W = $clog2(MAX_DATA + 1);
    localparam int NIB_W = $clog2((PRE_NIBBLES > 8) ? PRE_NIBBLES : 8);
    localparam logic [CNT_W-1:0] MIN_C     = CNT_W'(MIN_DATA);
    localparam logic [CNT_W-1:0] MAX_C     = CNT_W'(MAX_DATA);
    localparam logic [NIB_W-1:0] PRE_LAST  = NIB_W'(PRE_NIBBLES - 1);
    localparam logic [NIB_W-1:0] FCS_LAST  = NIB_W'(7);

    typedef struct packed {
        tx_state_e        state;
        logic [NIB_W-1:0] nib;
        logic [CNT_W-1:0] bytes;
        logic [7:0]       dat;
        logic             last;
        logic [31:0]      crc;
        logic [3:0]       txd;
        logic             tx_en;
        logic             col;
    } tx_reg_t;

    tx_reg_t     q, n;
    logic        col_s;
    logic        take;
    logic [7:0]  crc_data;
    logic [31:0] crc_next;

    mii_col_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_i(col_async), .sync_o(col_s)
    );

    mii_tx_crc i_crc (.crc_i(q.crc), .data_i(crc_data), .crc_o(crc_next));

    always_comb begin
        in_ready = (q.state == ST_IDLE) ||
                   (q.state == ST_HI && !q.last && q.bytes < MAX_C);
        take     = in_ready && in_valid && (q.state == ST_HI);
        if (q.state == ST_SFD) crc_data = q.dat;
        else if (take)         crc_data = in_data;
        else                   crc_data = 8'h00;
    end

    always_comb begin
        n = q;
        case (q.state)
            ST_IDLE: begin
                n.txd   = 4'h0;
                n.tx_en = 1'b0;
                if (in_valid && in_sop) begin
                    n.state = ST_PRE;
                    n.nib   = '0;
                    n.bytes = '0;
                    n.dat   = in_data;
                    n.last  = in_eop;
                    n.crc   = '1;
                    n.col   = 1'b0;
                    n.txd   = 4'h5;
                    n.tx_en = 1'b1;
                end
            end
            ST_PRE: begin
                if (q.nib == PRE_LAST) begin
                    n.state = ST_SFD;
                    n.txd   = 4'hD;
                end else begin
                    n.nib = q.nib + 1'b1;
                    n.txd = 4'h5;
                end
            end
            ST_SFD: begin
                n.state = ST_LO;
                n.txd   = q.dat[3:0];
                n.crc   = crc_next;
                n.bytes = q.bytes + 1'b1;
            end
            ST_LO: begin
                n.state = ST_HI;
                n.txd   = q.dat[7:4];
            end
            ST_PAD_LO: begin
                n.state = ST_PAD_HI;
                n.txd   = 4'h0;
            end
            ST_HI, ST_PAD_HI: begin
                if (take) begin
                    n.state = ST_LO;
                    n.dat   = in_data;
                    n.last  = in_eop;
                    n.txd   = in_data[3:0];
                    n.crc   = crc_next;
                    n.bytes = q.bytes + 1'b1;
                end else if (q.bytes < MIN_C) begin
                    n.state = ST_PAD_LO;
                    n.txd   = 4'h0;
                    n.crc   = crc_next;
                    n.bytes = q.bytes + 1'b1;
                end else begin
                    n.state = ST_FCS;
                    n.nib   = '0;
                    n.txd   = ~q.crc[3:0];
                    n.crc   = (~q.crc) >> 4;
                end
            end
            ST_FCS: begin
                if (q.nib == FCS_LAST) begin
                    n.state = ST_IDLE;
                    n.txd   = 4'h0;
                    n.tx_en = 1'b0;
                end else begin
                    n.nib = q.nib + 1'b1;
                    n.txd = q.crc[3:0];
                    n.crc = q.crc >> 4;
                end
            end
            default: n.state = ST_IDLE;
        endcase
        if (q.tx_en && col_s) n.col = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign txd      = q.txd;
    assign tx_en    = q.tx_en;
    assign col_flag = q.col;

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (txd == 4'h0));
    // R2
    first_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (txd == 4'h5));
    // R7
    end_after_fcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> ($past(q.state) == ST_FCS));
    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(col_flag) |-> $rose(tx_en));
    // R11
    no_ready_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PRE || q.state == ST_SFD) |-> !in_ready);
endmodule

// File: tb/test_mii_tx_framer.sv
module test_mii_tx_framer;
    localparam int CLK_PERIOD = 40;
    localparam int NCASE = 6;
    localparam int CASES [NCASE][2] = '{
        '{1, 8'h11}, '{59, 8'h3C}, '{60, 8'hA5}, '{61, 8'h07}, '{64, 8'hF0}, '{200, 8'h5A}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic       in_ready;
    logic       col_async = 1'b0;
    logic [3:0] txd;
    logic       tx_en, col_flag;

    int checks = 0, failures = 0;
    logic [3:0] cap [4096];
    int cap_n = 0, idle_err = 0, pre_rdy_err = 0, low_run = 0, last_gap = 0;
    logic prev_en = 1'b0;
    logic [3:0] expn [4096];
    int exp_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    mii_tx_framer i_mii_tx_framer (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
        .col_async(col_async), .txd(txd), .tx_en(tx_en), .col_flag(col_flag)
    );

    always @(negedge clk) begin
        if (tx_en) begin
            if (!prev_en) last_gap = low_run;
            if (cap_n < 4096) cap[cap_n] = txd;
            if (cap_n < 16 && in_ready) pre_rdy_err++;
            cap_n++;
            low_run = 0;
        end else begin
            if (rst_n && txd != 4'h0) idle_err++;
            low_run++;
        end
        prev_en = tx_en;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 7) & 255);
    endfunction

    task automatic feed(input int len, input int seed, input bit with_eop);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pat(seed, i);
            in_sop   = (i == 0);
            in_eop   = with_eop && (i == len - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic wait_done();
        do begin @(negedge clk); #1; end while (!(cap_n > 0 && !tx_en));
    endtask

    task automatic check_frame(input int len, input int seed, input string tag);
        logic [31:0] c;
        logic [7:0]  b;
        int total, bad_pre, bad_dat, bad_fcs, pos;
        total = (len < 60) ? 60 : len;
        exp_n = 0;
        for (int i = 0; i < 15; i++) expn[exp_n++] = 4'h5;
        expn[exp_n++] = 4'hD;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < total; i++) begin
            b = (i < len) ? pat(seed, i) : 8'h00;
            expn[exp_n++] = b[3:0];
            expn[exp_n++] = b[7:4];
            for (int k = 0; k < 8; k++)
                c = c[0] ^ b[k] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        for (int k = 0; k < 8; k++) expn[exp_n++] = c[4*k +: 4];
        chk(cap_n == exp_n, {tag, " R7 R5 frame nibble count"}, cap_n, exp_n);
        bad_pre = -1; bad_dat = -1; bad_fcs = -1;
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            if (cap[i] != expn[i]) begin
                if (i < 16 && bad_pre < 0) bad_pre = i;
                else if (i >= exp_n - 8 && bad_fcs < 0) bad_fcs = i;
                else if (i >= 16 && i < exp_n - 8 && bad_dat < 0) bad_dat = i;
            end
        end
        pos = (bad_pre < 0) ? 0 : bad_pre;
        chk(bad_pre < 0, {tag, " R3 preamble/delimiter"}, int'(cap[pos]), int'(expn[pos]));
        pos = (bad_dat < 0) ? 16 : bad_dat;
        chk(bad_dat < 0, {tag, " R4 R5 payload and pad nibbles"}, int'(cap[pos]), int'(expn[pos]));
        pos = (bad_fcs < 0) ? exp_n - 8 : bad_fcs;
        chk(bad_fcs < 0, {tag, " R6 CRC nibbles"}, int'(cap[pos]), int'(expn[pos]));
        chk(pre_rdy_err == 0, {tag, " R11 ready low in preamble"}, pre_rdy_err, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_en == 0 && txd == 0, "R1 reset outputs", {tx_en, txd}, 0);
        chk(in_ready == 1 && col_flag == 0, "R1 reset ready/flag", {in_ready, col_flag}, 2);

        for (int t = 0; t < NCASE; t++) begin
            cap_n = 0;
            feed(CASES[t][0], CASES[t][1], 1'b1);
            wait_done();
            check_frame(CASES[t][0], CASES[t][1], $sformatf("case%0d", t));
        end

        // R2 bytes without start marker in idle are dropped
        cap_n = 0;
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b0; in_data = 8'hEE;
        repeat (5) @(negedge clk);
        chk(in_ready == 1, "R2 idle ready while dropping", in_ready, 1);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(cap_n == 0, "R2 no frame without sop", cap_n, 0);

        // R8 underrun
        cap_n = 0;
        feed(3, 8'h21, 1'b0);
        wait_done();
        check_frame(3, 8'h21, "underrun R8");

        // R9 maximum length
        cap_n = 0;
        feed(1514, 8'h33, 1'b0);
        in_valid = 1'b1; in_data = 8'h99;
        seen = 0;
        repeat (4) begin @(negedge clk); if (in_ready) seen++; end
        chk(seen == 0, "R9 ready low after max bytes", seen, 0);
        in_valid = 1'b0;
        wait_done();
        check_frame(1514, 8'h33, "max R9");

        // R7 back-to-back gap
        cap_n = 0;
        feed(20, 8'h44, 1'b1);
        feed(20, 8'h55, 1'b1);
        wait_done();
        chk(last_gap == 1, "R7 idle gap between frames", last_gap, 1);
        chk(idle_err == 0, "R1 txd zero while idle", idle_err, 0);

        // R10 collision during frame sets sticky flag
        cap_n = 0;
        fork
            feed(30, 8'h66, 1'b1);
            begin
                repeat (30) @(negedge clk);
                col_async = 1'b1;
                repeat (4) @(negedge clk);
                col_async = 1'b0;
            end
        join
        wait_done();
        repeat (5) @(negedge clk);
        chk(col_flag == 1, "R10 flag sticky after frame", col_flag, 1);

        // R10 flag clears at next frame start
        cap_n = 0;
        fork
            feed(10, 8'h77, 1'b1);
            begin
                do begin @(negedge clk); #1; end while (!tx_en);
                chk(col_flag == 0, "R10 flag cleared with tx_en rise", col_flag, 0);
            end
        join
        wait_done();

        // R10 collision in idle ignored
        repeat (2) @(negedge clk);
        col_async = 1'b1;
        repeat (6) @(negedge clk);
        col_async = 1'b0;
        repeat (4) @(negedge clk);
        chk(col_flag == 0, "R10 idle collision ignored", col_flag, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule